// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block sits beside a processor core and decides which exception the core should run next. It watches a parameterised set of external interrupt lines (default 32) and one non-maskable input. Each external line has a programmable enable and a programmable 3-bit urgency. A rising edge on an enabled line, or a software write, marks that line pending. The most urgent pending request is offered to the core together with its exception number and the byte address of its vector-table word. The offer is made only if that request is strictly more urgent than the level the core is running at.

When the core accepts the offer, the request stops being pending. The level the core was running at, and the exception it was serving, are pushed onto a nesting stack, and the accepted exception becomes the running one. A one-cycle return pulse from the core pops the stack, so handlers unwind in reverse order. The non-maskable input outranks every programmable level and cannot be disabled.

The offer uses a valid/ready handshake. `exc_valid` is raised while a qualifying request exists. The core accepts it by raising `exc_ready` in a cycle where `exc_valid` is high. While `exc_ready` stays low, the offer is not frozen: a more urgent request arriving in the meantime replaces the number and address on the following cycle. A request that loses its qualification (for example, its pending bit is cleared by software) is withdrawn. The core must therefore treat only the values present in the accepting cycle as binding.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, every line is disabled, nothing is pending, `exc_valid` is low, `run_level` is all ones (the idle level, below every request) and `active_num` is 0.
- R2: A 0-to-1 transition on an enabled line, seen at a clock edge, sets that line pending from the next cycle on. An edge on a disabled line is ignored and is not remembered when the line is enabled later. A line held high does not set the pending bit again.
- R3: A configuration write (`cfg_wr` high for one cycle) addresses line `cfg_line` with the operation in `cfg_op`:
  - 0 writes the enable from `cfg_data[0]`;
  - 1 sets the pending bit;
  - 2 clears the pending bit;
  - 3 writes the 3-bit urgency from `cfg_data`.
- R4: Among lines that are both enabled and pending, the smallest urgency value wins, and a tie goes to the lower line index. The running level of line k is its urgency plus 1.
- R5: `exc_valid` is high only if the winning level is strictly below `run_level`. A request of equal or lower urgency waits until the handler at that level returns.
- R6: External line k is offered as exception number 16+k, and the non-maskable input as number 2. `exc_vector` equals the exception number times 4.
- R7: A rising edge on `nmi_in` makes a non-maskable request pending at level 0, which beats every line. While a non-maskable handler runs at level 0, nothing is offered, including a new non-maskable request.
- R8: In a cycle with `exc_valid` and `exc_ready` both high, the offered request is no longer pending on the next cycle. From that cycle on, `run_level` equals the offered level and `active_num` equals the offered number.
- R9: A one-cycle `exc_return` restores the `run_level` and `active_num` that were in force before the most recent accepted exception. It is ignored when nothing is active, and it is ignored in a cycle where an exception is accepted.
- R10: The nesting stack holds one entry per possible level (2^3 line levels plus the non-maskable level, 9 in total), so a full chain can be taken and unwound without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | External interrupt lines, synchronous to clk |
| nmi_in | input | 1 | Non-maskable request input, edge sensitive |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Operation: 0 enable, 1 pend set, 2 pend clear, 3 urgency |
| cfg_line | input | LINE_IDX_W | Line addressed by the write |
| cfg_data | input | PRIO_W | Enable in bit 0, or the urgency value |
| exc_valid | output | 1 | An exception is offered to the core |
| exc_ready | input | 1 | Core accepts the offered exception |
| exc_num | output | 9 | Offered exception number |
| exc_vector | output | 32 | Byte address of the vector-table word |
| exc_return | input | 1 | Pulse: the current handler has finished |
| run_level | output | PRIO_W+1 | Level of the running handler, all ones when idle |
| active_num | output | 9 | Exception number now running, 0 when idle |

## Verification
A line edge or a configuration write presented before a rising clock edge shows up on `exc_valid`, `exc_num` and `exc_vector` right after that edge. Acceptance and return show up on `run_level` and `active_num` after the same single edge. No output depends combinationally on an input.

The bench drives every input at the falling edge and updates its reference model at the rising edge, using the inputs the design sampled. It compares all outputs at the next falling edge, so every result is checked in the first cycle it is due. Directed sequences pin down exact numbers and addresses for:
- tie-breaking;
- equal-level waiting;
- two-level nesting;
- non-maskable preemption;
- a full nine-deep chain.

A seeded random phase then mixes edges, writes, acceptances and returns.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int EXC_NUM_W = 9;
  localparam int EXT_BASE = 16;
  localparam logic [EXC_NUM_W-1:0] NMI_EXC_NUM = 9'd2;

  typedef enum logic [1:0] {
    CFG_ENABLE   = 2'd0,
    CFG_PEND_SET = 2'd1,
    CFG_PEND_CLR = 2'd2,
    CFG_PRIO     = 2'd3
  } cfg_op_e;

  // Vector-table word for an exception: one 32-bit word per number.
  function automatic logic [31:0] vec_addr(input logic [EXC_NUM_W-1:0] num);
    return 32'(num) << 2;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_nest_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W = 3,
  parameter int LINE_IDX_W = 5,
  parameter int LVL_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0]            irq_lines,
  input  logic                            cfg_wr,
  input  cfg_op_e                         cfg_op,
  input  logic [LINE_IDX_W-1:0]           cfg_line,
  input  logic [PRIO_W-1:0]               cfg_data,
  input  logic                            take_hit,
  input  logic [LINE_IDX_W-1:0]           take_line,
  output logic [NUM_LINES-1:0]            req_vld,
  output logic [NUM_LINES-1:0][LVL_W-1:0] req_lvl
);

  logic [NUM_LINES-1:0] irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_lines;
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic              en_q;
    logic              pend_q;
    logic [PRIO_W-1:0] prio_q;
    logic              sel;
    logic              set_k;
    logic              clr_k;

    assign sel   = cfg_wr && (cfg_line == LINE_IDX_W'(k));
    assign set_k = (irq_lines[k] && !irq_q[k] && en_q)
                 || (sel && cfg_op == CFG_PEND_SET);
    assign clr_k = (take_hit && take_line == LINE_IDX_W'(k))
                 || (sel && cfg_op == CFG_PEND_CLR);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        prio_q <= '0;
      end else begin
        pend_q <= (pend_q && !clr_k) || set_k;
        if (sel && cfg_op == CFG_ENABLE) en_q <= cfg_data[0];
        if (sel && cfg_op == CFG_PRIO)   prio_q <= cfg_data;
      end
    end

    assign req_vld[k] = en_q && pend_q;
    assign req_lvl[k] = LVL_W'(prio_q) + LVL_W'(1);

    AST_PEND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (take_hit && take_line == LINE_IDX_W'(k) && !set_k) |=> !pend_q); // R8
  end

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int NUM_LINES = 32,
  parameter int LVL_W = 4,
  parameter int IDX_W = 5
) (
  input  logic [NUM_LINES-1:0]            req_vld,
  input  logic [NUM_LINES-1:0][LVL_W-1:0] req_lvl,
  output logic                            win_vld,
  output logic [LVL_W-1:0]                win_lvl,
  output logic [IDX_W-1:0]                win_idx
);

  localparam int STAGES = $clog2(NUM_LINES);
  localparam int LEAVES = 1 << STAGES;

  for (genvar s = 0; s <= STAGES; s++) begin : stg
    localparam int W = LEAVES >> s;
    logic             vld [W];
    logic [LVL_W-1:0] lvl [W];
    logic [IDX_W-1:0] idx [W];

    for (genvar j = 0; j < W; j++) begin : nd
      if (s == 0) begin : g_leaf
        if (j < NUM_LINES) begin : g_used
          assign vld[j] = req_vld[j];
          assign lvl[j] = req_lvl[j];
        end else begin : g_pad
          assign vld[j] = 1'b0;
          assign lvl[j] = '1;
        end
        assign idx[j] = IDX_W'(j);
      end else begin : g_join
        // Right (higher index) only wins when strictly more urgent.
        logic pick_r;
        assign pick_r = stg[s-1].vld[2*j+1]
                      && (!stg[s-1].vld[2*j]
                          || stg[s-1].lvl[2*j+1] < stg[s-1].lvl[2*j]);
        assign vld[j] = stg[s-1].vld[2*j] || stg[s-1].vld[2*j+1];
        assign lvl[j] = pick_r ? stg[s-1].lvl[2*j+1] : stg[s-1].lvl[2*j];
        assign idx[j] = pick_r ? stg[s-1].idx[2*j+1] : stg[s-1].idx[2*j];
      end
    end
  end

  assign win_vld = stg[STAGES].vld[0];
  assign win_lvl = stg[STAGES].lvl[0];
  assign win_idx = stg[STAGES].idx[0];

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int LVL_W = 4,
  parameter int NUM_W = 9,
  parameter int DEPTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic [NUM_W-1:0] push_num,
  input  logic             pop,
  output logic [LVL_W-1:0] run_lvl,
  output logic [NUM_W-1:0] run_num
);

  localparam int SP_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] sv_lvl [DEPTH];
  logic [NUM_W-1:0] sv_num [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [LVL_W-1:0] cur_lvl;
  logic [NUM_W-1:0] cur_num;
  logic             do_pop;

  assign do_pop = pop && !push && (sp != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= '0;
      cur_lvl <= '1;
      cur_num <= '0;
    end else if (push) begin
      sp      <= sp + SP_W'(1);
      cur_lvl <= push_lvl;
      cur_num <= push_num;
    end else if (do_pop) begin
      sp      <= sp - SP_W'(1);
      cur_lvl <= sv_lvl[sp - SP_W'(1)];
      cur_num <= sv_num[sp - SP_W'(1)];
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      sv_lvl[sp] <= cur_lvl;
      sv_num[sp] <= cur_num;
    end
  end

  assign run_lvl = cur_lvl;
  assign run_num = cur_num;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sp < SP_W'(DEPTH))); // R10
  AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (cur_lvl > $past(cur_lvl))); // R9

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W = 3,
  localparam int LINE_IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int LVL_W = PRIO_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_lines,
  input  logic                  nmi_in,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_op,
  input  logic [LINE_IDX_W-1:0] cfg_line,
  input  logic [PRIO_W-1:0]     cfg_data,
  output logic                  exc_valid,
  input  logic                  exc_ready,
  output logic [EXC_NUM_W-1:0]  exc_num,
  output logic [31:0]           exc_vector,
  input  logic                  exc_return,
  output logic [LVL_W-1:0]      run_level,
  output logic [EXC_NUM_W-1:0]  active_num
);

  localparam int NEST_DEPTH = (1 << PRIO_W) + 1;

  logic [NUM_LINES-1:0]            req_vld;
  logic [NUM_LINES-1:0][LVL_W-1:0] req_lvl;
  logic                            t_vld;
  logic [LVL_W-1:0]                t_lvl;
  logic [LINE_IDX_W-1:0]           t_idx;
  logic                            nmi_q;
  logic                            nmi_pend;
  logic                            offer_vld;
  logic [LVL_W-1:0]                offer_lvl;
  logic [EXC_NUM_W-1:0]            offer_num;
  logic                            take;
  logic                            take_line;

  irq_src_bank #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W),
    .LINE_IDX_W(LINE_IDX_W), .LVL_W(LVL_W)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .cfg_wr(cfg_wr), .cfg_op(cfg_op_e'(cfg_op)), .cfg_line(cfg_line),
    .cfg_data(cfg_data), .take_hit(take_line), .take_line(t_idx),
    .req_vld(req_vld), .req_lvl(req_lvl)
  );

  irq_prio_tree #(
    .NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .IDX_W(LINE_IDX_W)
  ) tree_i (
    .req_vld(req_vld), .req_lvl(req_lvl),
    .win_vld(t_vld), .win_lvl(t_lvl), .win_idx(t_idx)
  );

  // Non-maskable source: edge detected, always enabled, level 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= (nmi_pend && !(take && nmi_pend)) || (nmi_in && !nmi_q);
    end
  end

  assign offer_vld = nmi_pend || t_vld;
  assign offer_lvl = nmi_pend ? '0 : t_lvl;
  assign offer_num = nmi_pend ? NMI_EXC_NUM
                              : EXC_NUM_W'(EXT_BASE) + EXC_NUM_W'(t_idx);

  assign exc_valid  = offer_vld && (offer_lvl < run_level);
  assign take       = exc_valid && exc_ready;
  assign take_line  = take && !nmi_pend;
  assign exc_num    = offer_num;
  assign exc_vector = vec_addr(offer_num);

  irq_nest_stack #(
    .LVL_W(LVL_W), .NUM_W(EXC_NUM_W), .DEPTH(NEST_DEPTH)
  ) stack_i (
    .clk(clk), .rst_n(rst_n),
    .push(take), .push_lvl(offer_lvl), .push_num(offer_num),
    .pop(exc_return),
    .run_lvl(run_level), .run_num(active_num)
  );

  AST_TAKE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (run_level == $past(offer_lvl) && active_num == $past(offer_num))); // R8
  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (run_level < $past(run_level))); // R5
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && run_level != '0) |-> (exc_valid && exc_num == NMI_EXC_NUM)); // R7
  AST_IDLE_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    (run_level == '1) |-> (active_num == '0)); // R9

endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;

  localparam int N = 32;
  localparam int IW = 5;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_lines = '0;
  logic          nmi_in = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_op = '0;
  logic [IW-1:0] cfg_line = '0;
  logic [2:0]    cfg_data = '0;
  logic          exc_valid;
  logic          exc_ready = 1'b0;
  logic [8:0]    exc_num;
  logic [31:0]   exc_vector;
  logic          exc_return = 1'b0;
  logic [LW-1:0] run_level;
  logic [8:0]    active_num;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_nest_ctrl #(.NUM_LINES(N), .PRIO_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_in(nmi_in),
    .cfg_wr(cfg_wr), .cfg_op(cfg_op), .cfg_line(cfg_line), .cfg_data(cfg_data),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_num(exc_num),
    .exc_vector(exc_vector), .exc_return(exc_return),
    .run_level(run_level), .active_num(active_num)
  );

  // Reference model, built from the requirements.
  bit       m_en   [N];
  bit       m_pend [N];
  bit [2:0] m_prio [N];
  bit [N-1:0] m_line_q;
  bit       m_nmi_q, m_nmi_pend;
  int       m_run_lvl, m_run_num, m_sp;
  int       m_stk_lvl [16];
  int       m_stk_num [16];

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_en[k] = 0; m_pend[k] = 0; m_prio[k] = 0;
    end
    m_line_q = '0; m_nmi_q = 0; m_nmi_pend = 0;
    m_run_lvl = 15; m_run_num = 0; m_sp = 0;
  endtask

  task automatic best(output bit v, output int lvl, output int num);
    v = 0; lvl = 99; num = 0;
    if (m_nmi_pend) begin
      v = 1; lvl = 0; num = 2;
    end else begin
      for (int k = 0; k < N; k++)
        if (m_en[k] && m_pend[k] && (int'(m_prio[k]) + 1 < lvl)) begin
          v = 1; lvl = int'(m_prio[k]) + 1; num = 16 + k;
        end
    end
  endtask

  task automatic model_edge();
    bit v; int lvl, num; bit take;
    bit set_k, clr_k, sel;
    best(v, lvl, num);
    take = v && (lvl < m_run_lvl) && exc_ready;
    for (int k = 0; k < N; k++) begin
      sel   = cfg_wr && (int'(cfg_line) == k);
      set_k = (irq_lines[k] && !m_line_q[k] && m_en[k]) || (sel && cfg_op == 2'd1);
      clr_k = (take && !m_nmi_pend && num == 16 + k) || (sel && cfg_op == 2'd2);
      m_pend[k] = (m_pend[k] && !clr_k) || set_k;
      if (sel && cfg_op == 2'd0) m_en[k] = cfg_data[0];
      if (sel && cfg_op == 2'd3) m_prio[k] = cfg_data;
    end
    m_nmi_pend = (m_nmi_pend && !(take && m_nmi_pend)) || (nmi_in && !m_nmi_q);
    m_nmi_q = nmi_in;
    m_line_q = irq_lines;
    if (take) begin
      m_stk_lvl[m_sp] = m_run_lvl; m_stk_num[m_sp] = m_run_num; m_sp++;
      m_run_lvl = lvl; m_run_num = num;
    end else if (exc_return && m_sp > 0) begin
      m_sp--;
      m_run_lvl = m_stk_lvl[m_sp]; m_run_num = m_stk_num[m_sp];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit v; int lvl, num; bit ev;
    best(v, lvl, num);
    ev = v && (lvl < m_run_lvl);
    chk("R5 offer valid", 32'(exc_valid), 32'(ev));
    if (ev) begin
      chk("R4 winner number", 32'(exc_num), 32'(num));
      chk("R6 vector address", exc_vector, 32'(num * 4));
    end
    chk("R8 running level", 32'(run_level), 32'(m_run_lvl));
    chk("R9 active number", 32'(active_num), 32'(m_run_num));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    cfg_wr = 0; exc_ready = 0; exc_return = 0;
  endtask

  task automatic cfg(input int op, input int line, input int data);
    cfg_wr = 1; cfg_op = 2'(op); cfg_line = IW'(line); cfg_data = 3'(data);
    tick();
  endtask

  task automatic pulse_line(input int k);
    irq_lines[k] = 1'b1; tick();
    irq_lines[k] = 1'b0; tick();
  endtask

  task automatic take_it();
    exc_ready = 1; tick();
  endtask

  task automatic ret();
    exc_return = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 valid after reset", 32'(exc_valid), 32'd0);
    chk("R1 idle level", 32'(run_level), 32'hF);
    chk("R1 active idle", 32'(active_num), 32'd0);
    pulse_line(0);
    chk("R1 lines disabled", 32'(exc_valid), 32'd0);

    // R2, R3, R6: single request
    cfg(0, 3, 1); cfg(3, 3, 5);
    pulse_line(3);
    chk("R2 edge pends", 32'(exc_valid), 32'd1);
    chk("R6 number line 3", 32'(exc_num), 32'd19);
    chk("R6 vector line 3", exc_vector, 32'h4C);
    cfg(2, 3, 0);
    chk("R3 pend clear", 32'(exc_valid), 32'd0);
    cfg(1, 3, 0);
    chk("R3 pend set", 32'(exc_num), 32'd19);

    // R2: edge on a disabled line is dropped
    pulse_line(4);
    cfg(3, 4, 0); cfg(0, 4, 1);
    chk("R2 disabled edge dropped", 32'(exc_num), 32'd19);

    // R4: tie on level, lower index wins
    cfg(0, 5, 1); cfg(3, 5, 2); cfg(0, 9, 1); cfg(3, 9, 2);
    irq_lines[5] = 1; irq_lines[9] = 1; tick();
    irq_lines[5] = 0; irq_lines[9] = 0; tick();
    chk("R4 tie lower index", 32'(exc_num), 32'd21);

    // R8, R5: take, equal level waits
    take_it();
    chk("R8 level after take", 32'(run_level), 32'd3);
    chk("R5 equal level waits", 32'(exc_valid), 32'd0);

    // two-level nesting
    cfg(0, 6, 1); cfg(3, 6, 1); cfg(1, 6, 0);
    chk("R5 more urgent preempts", 32'(exc_num), 32'd22);
    take_it();
    chk("R8 nested active", 32'(active_num), 32'd22);

    // R7: non-maskable preemption
    nmi_in = 1; tick();
    chk("R7 nmi number", 32'(exc_num), 32'd2);
    chk("R7 nmi vector", exc_vector, 32'h8);
    take_it();
    chk("R7 nmi level", 32'(run_level), 32'd0);
    nmi_in = 0; tick(); nmi_in = 1; tick(); nmi_in = 0; tick();
    chk("R7 nmi not preempted", 32'(exc_valid), 32'd0);
    ret();
    chk("R9 return restores", 32'(active_num), 32'd22);
    chk("R7 second nmi offered", 32'(exc_num), 32'd2);
    take_it(); ret(); ret(); ret();
    chk("R9 back to idle", 32'(run_level), 32'hF);
    take_it(); ret(); take_it(); ret();
    ret();
    chk("R9 return when idle ignored", 32'(run_level), 32'hF);

    // R10: full chain of nine levels
    for (int k = 0; k < N; k++) cfg(0, k, 0);
    for (int k = 0; k < 8; k++) begin
      cfg(0, 10 + k, 1); cfg(3, 10 + k, 7 - k); cfg(1, 10 + k, 0);
      take_it();
    end
    nmi_in = 1; tick(); take_it(); nmi_in = 0; tick();
    chk("R10 deepest active", 32'(active_num), 32'd2);
    chk("R10 deepest level", 32'(run_level), 32'd0);
    for (int i = 0; i < 9; i++) ret();
    chk("R10 unwound", 32'(run_level), 32'hF);

    // Random phase
    for (int it = 0; it < 4000; it++) begin
      if ($urandom_range(0, 3) == 0) irq_lines[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 63) == 0) nmi_in = ~nmi_in;
      if ($urandom_range(0, 3) == 0) begin
        cfg_wr = 1; cfg_op = 2'($urandom_range(0, 3));
        cfg_line = IW'($urandom_range(0, N-1)); cfg_data = 3'($urandom_range(0, 7));
      end
      exc_ready  = ($urandom_range(0, 2) == 0);
      exc_return = ($urandom_range(0, 5) == 0);
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule